// File: doc/BRIEF.md
# Translation Buffer with Two-Level Table Walker

This block turns 32-bit virtual addresses into physical addresses for 4 KB pages. It keeps eight recently used translations in a fully associative buffer. On a hit, it answers in the same cycle as the request. The answer carries the physical address, a dirty indication, and a protection verdict based on the access type and the privilege of the requester.

On a miss, a hardware walker reads two table words from physical memory over a read port with a valid/ready request and a response valid. It then installs the translation, or reports a page fault when either table word is marked absent. The requester holds its request until `resp_valid` is seen, and the walker uses that held address throughout. A flush input empties the buffer.

Top module: `vat_unit`

## Requirements
- R1: A virtual address splits into a first-level index (bits 31:22), a second-level index (bits 21:12) and an offset (bits 11:0). The first table read is at {pt_root, first index, 00}. The second read is at {PPN of the first word, second index, 00}.
- R2: On a hit, `resp_valid` rises in the same cycle as the request with `resp_paddr` = {PPN, offset}, and no memory read is issued.
- R3: On a miss, `req_ready` drops and exactly two table reads take place. The buffer is then refilled, and the held request hits in the cycle after the refill.
- R4: The table word layout is: bit 0 present, bit 1 readable, bit 2 writable, bit 3 dirty, bit 4 user-accessible, bits 31:12 PPN.
- R5: If either table word has bit 0 clear, `resp_valid` and `resp_pfault` are high together for one cycle and nothing is installed, so a repeated access walks again.
- R6: A read needs the readable bit and a write needs the writable bit. A user-mode access also needs the user bit, which kernel mode ignores. A denied access gives `resp_prfault` = 1.
- R7: `resp_dirty` reports the dirty bit of the matched entry before the access. A permitted write sets that bit; a denied write leaves it clear.
- R8: The buffer holds 8 entries and replaces them in first-in first-out order.
- R9: `flush` invalidates every entry in one cycle. A hit presented in the flush cycle is still answered. When a flush and a refill fall in the same cycle, the flush wins.
- R10: A memory request holds its address until `mem_req_ready`, and any response latency is accepted.
- R11: After reset, the buffer is empty, `req_ready` = 1, and no memory request or response is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate all entries |
| pt_root | input | 20 | Frame number of the first-level table |
| req_valid | input | 1 | Translation request, held until resp_valid |
| req_vaddr | input | 32 | Virtual address |
| req_write | input | 1 | 1 = write access |
| req_user | input | 1 | 1 = user mode, 0 = kernel mode |
| req_ready | output | 1 | No walk in progress |
| resp_valid | output | 1 | Response present this cycle |
| resp_paddr | output | 32 | Physical address |
| resp_dirty | output | 1 | Dirty bit of the matched entry |
| resp_pfault | output | 1 | Page fault |
| resp_prfault | output | 1 | Protection fault |
| mem_req_valid | output | 1 | Table read request |
| mem_req_addr | output | 32 | Table word address |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_rsp_valid | input | 1 | Read data present |
| mem_rsp_data | input | 32 | Table word |

## Verification
A flush can coincide with either a lookup hit or the walker's refill cycle. Both cases are driven on purpose. In the first, a cached page is requested in the same cycle that `flush` is raised: the bench expects a same-cycle answer, then a fresh two-read walk on the next access. In the second, the bench watches the second table response and raises `flush` exactly in the following refill cycle. It then expects the held request to walk a second time, making four reads in total, before it hits.

// File: rtl/vat_pkg.sv
package vat_pkg;
    localparam int VA_W   = 32;
    localparam int OFF_W  = 12;
    localparam int IDX_W  = 10;
    localparam int VPN_W  = VA_W - OFF_W;
    localparam int PPN_W  = 20;
    localparam int FLAG_W = 5;

    // table word bit positions
    localparam int B_PRES = 0;
    localparam int B_RD   = 1;
    localparam int B_WR   = 2;
    localparam int B_DIRT = 3;
    localparam int B_USR  = 4;

    typedef struct packed {
        logic [VPN_W-1:0] vpn;
        logic [PPN_W-1:0] ppn;
        logic             v;
        logic             r;
        logic             w;
        logic             d;
        logic             u;
    } tlb_ent_t;

    typedef enum logic [2:0] {
        W_IDLE, W_L1_REQ, W_L1_WAIT, W_L2_REQ, W_L2_WAIT, W_REFILL, W_FAULT
    } walk_st_t;
endpackage

// File: rtl/vat_tlb.sv
module vat_tlb
    import vat_pkg::*;
#(
    parameter int ENTRIES = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic [VPN_W-1:0] lk_vpn,
    input  logic             set_dirty,
    input  logic             refill_en,
    input  tlb_ent_t         refill_ent,
    output logic             hit,
    output tlb_ent_t         hit_ent
);
    localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    typedef struct packed {
        tlb_ent_t [ENTRIES-1:0] ent;
        logic [PTR_W-1:0]       ptr;
    } tlb_st_t;

    tlb_st_t s_d, s_q;
    logic [ENTRIES-1:0] match;
    logic [ENTRIES-1:0] valid_vec;
    logic [PTR_W-1:0]   hit_idx;

    for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
        assign match[i]     = s_q.ent[i].v && (s_q.ent[i].vpn == lk_vpn);
        assign valid_vec[i] = s_q.ent[i].v;
    end

    always_comb begin
        hit_idx = '0;
        for (int i = 0; i < ENTRIES; i++)
            if (match[i]) hit_idx = PTR_W'(i);
    end

    assign hit     = |match;
    assign hit_ent = s_q.ent[hit_idx];

    always_comb begin
        s_d = s_q;
        if (set_dirty && hit)
            s_d.ent[hit_idx].d = 1'b1;
        if (refill_en) begin
            s_d.ent[s_q.ptr] = refill_ent;
            s_d.ptr = (s_q.ptr == PTR_W'(ENTRIES-1)) ? '0 : s_q.ptr + 1'b1;
        end
        if (flush)
            for (int i = 0; i < ENTRIES; i++) s_d.ent[i].v = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // at most one entry matches any page
    p_unique_hit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match));
    // flush empties the buffer by the next cycle
    p_flush_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (valid_vec == '0));
endmodule

// File: rtl/vat_walker.sv
module vat_walker
    import vat_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [VPN_W-1:0] vpn_in,
    input  logic [PPN_W-1:0] pt_root,
    input  logic             mem_req_ready,
    input  logic             mem_rsp_valid,
    input  logic [VA_W-1:0]  mem_rsp_data,
    output logic             busy,
    output logic             mem_req_valid,
    output logic [VA_W-1:0]  mem_req_addr,
    output logic             refill_en,
    output tlb_ent_t         refill_ent,
    output logic             fault
);
    typedef struct packed {
        walk_st_t          st;
        logic [VPN_W-1:0]  vpn;
        logic [PPN_W-1:0]  frame;
        logic [FLAG_W-1:0] flags;
    } walk_t;

    walk_t w_d, w_q;

    always_comb begin
        w_d = w_q;
        unique case (w_q.st)
            W_IDLE:    if (start) begin
                           w_d.st  = W_L1_REQ;
                           w_d.vpn = vpn_in;
                       end
            W_L1_REQ:  if (mem_req_ready) w_d.st = W_L1_WAIT;
            W_L1_WAIT: if (mem_rsp_valid) begin
                           w_d.frame = mem_rsp_data[VA_W-1:OFF_W];
                           w_d.st    = mem_rsp_data[B_PRES] ? W_L2_REQ : W_FAULT;
                       end
            W_L2_REQ:  if (mem_req_ready) w_d.st = W_L2_WAIT;
            W_L2_WAIT: if (mem_rsp_valid) begin
                           w_d.frame = mem_rsp_data[VA_W-1:OFF_W];
                           w_d.flags = mem_rsp_data[FLAG_W-1:0];
                           w_d.st    = mem_rsp_data[B_PRES] ? W_REFILL : W_FAULT;
                       end
            W_REFILL:  w_d.st = W_IDLE;
            W_FAULT:   w_d.st = W_IDLE;
            default:   w_d.st = W_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) w_q <= '{st: W_IDLE, default: '0};
        else        w_q <= w_d;
    end

    assign busy          = (w_q.st != W_IDLE);
    assign mem_req_valid = (w_q.st == W_L1_REQ) || (w_q.st == W_L2_REQ);
    assign mem_req_addr  = (w_q.st == W_L1_REQ) ? {pt_root, w_q.vpn[VPN_W-1:IDX_W], 2'b00}
                         : (w_q.st == W_L2_REQ) ? {w_q.frame, w_q.vpn[IDX_W-1:0], 2'b00}
                         : '0;
    assign refill_en     = (w_q.st == W_REFILL);
    assign fault         = (w_q.st == W_FAULT);
    assign refill_ent    = '{vpn: w_q.vpn, ppn: w_q.frame,
                             v: 1'b1,
                             r: w_q.flags[B_RD],
                             w: w_q.flags[B_WR],
                             d: w_q.flags[B_DIRT],
                             u: w_q.flags[B_USR]};

    // a stalled request keeps its address
    p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));
    // a fault report lasts one cycle
    p_fault_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> !fault);
    // refill is never followed by a fault for the same walk
    p_refill_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
        refill_en |=> !busy);
endmodule

// File: rtl/vat_unit.sv
module vat_unit
    import vat_pkg::*;
#(
    parameter int ENTRIES = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic [PPN_W-1:0] pt_root,
    input  logic             req_valid,
    input  logic [VA_W-1:0]  req_vaddr,
    input  logic             req_write,
    input  logic             req_user,
    output logic             req_ready,
    output logic             resp_valid,
    output logic [VA_W-1:0]  resp_paddr,
    output logic             resp_dirty,
    output logic             resp_pfault,
    output logic             resp_prfault,
    output logic             mem_req_valid,
    output logic [VA_W-1:0]  mem_req_addr,
    input  logic             mem_req_ready,
    input  logic             mem_rsp_valid,
    input  logic [VA_W-1:0]  mem_rsp_data
);
    logic     hit, busy, refill_en, fault, deny, lk_hit;
    tlb_ent_t hit_ent, refill_ent;

    vat_tlb #(.ENTRIES(ENTRIES)) u_tlb (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (flush),
        .lk_vpn     (req_vaddr[VA_W-1:OFF_W]),
        .set_dirty  (lk_hit && req_write && !deny),
        .refill_en  (refill_en),
        .refill_ent (refill_ent),
        .hit        (hit),
        .hit_ent    (hit_ent)
    );

    vat_walker u_walk (
        .clk           (clk),
        .rst_n         (rst_n),
        .start         (req_valid && !busy && !hit),
        .vpn_in        (req_vaddr[VA_W-1:OFF_W]),
        .pt_root       (pt_root),
        .mem_req_ready (mem_req_ready),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .busy          (busy),
        .mem_req_valid (mem_req_valid),
        .mem_req_addr  (mem_req_addr),
        .refill_en     (refill_en),
        .refill_ent    (refill_ent),
        .fault         (fault)
    );

    assign lk_hit       = req_valid && !busy && hit;
    assign deny         = (req_write ? !hit_ent.w : !hit_ent.r) || (req_user && !hit_ent.u);
    assign req_ready    = !busy;
    assign resp_valid   = lk_hit || fault;
    assign resp_paddr   = lk_hit ? {hit_ent.ppn, req_vaddr[OFF_W-1:0]} : '0;
    assign resp_dirty   = lk_hit && hit_ent.d;
    assign resp_pfault  = fault;
    assign resp_prfault = lk_hit && deny;

    // the two fault kinds never coincide
    p_fault_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        resp_pfault |-> !resp_prfault);
    // no request is taken while the walker reads memory
    p_busy_block_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> (!req_ready && !resp_valid));
    // a fault answer carries no address
    p_pf_noaddr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        resp_pfault |-> (resp_paddr == '0));
endmodule

// File: tb/tb_vat_unit.sv
module tb_vat_unit;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        flush = 0;
    logic [19:0] pt_root = 20'h00010;
    logic        req_valid = 0;
    logic [31:0] req_vaddr = '0;
    logic        req_write = 0;
    logic        req_user = 0;
    logic        req_ready, resp_valid, resp_dirty, resp_pfault, resp_prfault;
    logic [31:0] resp_paddr;
    logic        mem_req_valid, mem_req_ready;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid = 0;
    logic [31:0] mem_rsp_data = '0;

    int errors = 0, checks = 0;
    int rd_count = 0;
    logic [31:0] rd_log [4];
    int lat = 0, rdy_delay = 0, wait_cnt = 0, pend_cnt = 0;
    logic pend = 0;
    logic [31:0] pend_addr = '0;
    logic saw_busy;

    always #2 clk = ~clk;

    vat_unit dut (.*);

    // table image: root frame 0x10, second-level frames 0x100..0x103
    function automatic logic [31:0] pt_word(input logic [31:0] a);
        logic [9:0] i2;
        i2 = a[11:2];
        if (a[31:12] == 20'h00010)
            return (i2 < 4) ? {20'h00100 + 20'(i2), 12'h001} : 32'h0;
        if (a[31:14] == 18'h00040) begin
            if (i2[3:0] == 4'hF) return 32'h0;
            return {20'h50000 | {8'h0, a[13:12], i2}, 7'h0,
                    ~i2[1], 1'b0, ~i2[0], (i2[3:0] != 4'hE), 1'b1};
        end
        return 32'h0;
    endfunction

    function automatic logic [31:0] exp_pa(input logic [31:0] va);
        return {20'h50000 | {8'h0, va[23:22], va[21:12]}, va[11:0]};
    endfunction

    function automatic logic [31:0] mkva(input int i1, input int i2, input int off);
        return {10'(i1), 10'(i2), 12'(off)};
    endfunction

    assign mem_req_ready = (wait_cnt == 0);

    always @(posedge clk) begin
        mem_rsp_valid <= 1'b0;
        if (mem_req_valid && !mem_req_ready) wait_cnt <= wait_cnt - 1;
        if (mem_req_valid && mem_req_ready) begin
            rd_log[rd_count % 4] <= mem_req_addr;
            rd_count  <= rd_count + 1;
            pend      <= 1'b1;
            pend_cnt  <= lat;
            pend_addr <= mem_req_addr;
            wait_cnt  <= rdy_delay;
        end else if (pend) begin
            if (pend_cnt == 0) begin
                mem_rsp_valid <= 1'b1;
                mem_rsp_data  <= pt_word(pend_addr);
                pend <= 1'b0;
            end else pend_cnt <= pend_cnt - 1;
        end
    end

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_resp(output int cyc);
        cyc = 0;
        saw_busy = 0;
        #1;
        while (!resp_valid && cyc < 300) begin
            if (!req_ready) saw_busy = 1;
            @(negedge clk); #1;
            cyc++;
        end
    endtask

    task automatic access(input logic [31:0] va, input logic wr, input logic usr,
                          output logic [31:0] pa, output logic pf, output logic prf,
                          output logic dty, output int reads, output int cyc);
        int r0;
        @(negedge clk);
        req_valid = 1; req_vaddr = va; req_write = wr; req_user = usr;
        r0 = rd_count;
        wait_resp(cyc);
        pa = resp_paddr; pf = resp_pfault; prf = resp_prfault; dty = resp_dirty;
        @(negedge clk);
        req_valid = 0;
        reads = rd_count - r0;
    endtask

    task automatic do_flush();
        @(negedge clk); flush = 1;
        @(negedge clk); flush = 0;
    endtask

    logic [31:0] pa; logic pf, prf, dty; int rd, cy;

    task automatic t_reset();
        #1;
        chk(req_ready === 1'b1, "R11 ready", 32'(req_ready), 1);
        chk(mem_req_valid === 1'b0, "R11 memreq", 32'(mem_req_valid), 0);
        chk(resp_valid === 1'b0, "R11 resp", 32'(resp_valid), 0);
        access(mkva(0, 3, 0), 0, 0, pa, pf, prf, dty, rd, cy);
        chk(rd == 2, "R11 empty after reset", rd, 2);
    endtask

    task automatic t_miss_hit();
        logic [31:0] va;
        va = mkva(1, 2, 12'h345);
        access(va, 0, 0, pa, pf, prf, dty, rd, cy);
        chk(rd == 2, "R3 two reads", rd, 2);
        chk(saw_busy, "R3 ready low in walk", 32'(saw_busy), 1);
        chk(rd_log[(rd_count - 2) % 4] == 32'h00010004, "R1 level1 addr", rd_log[(rd_count - 2) % 4], 32'h00010004);
        chk(rd_log[(rd_count - 1) % 4] == 32'h00101008, "R1 level2 addr", rd_log[(rd_count - 1) % 4], 32'h00101008);
        chk(pa == exp_pa(va) && !pf && !prf, "R4 refilled paddr", pa, exp_pa(va));
        access(va, 0, 0, pa, pf, prf, dty, rd, cy);
        chk(rd == 0 && cy == 0, "R2 same-cycle hit", 32'(rd * 256 + cy), 0);
        chk(pa == exp_pa(va), "R2 hit paddr", pa, exp_pa(va));
        access(mkva(1, 2, 12'hFFC), 0, 0, pa, pf, prf, dty, rd, cy);
        chk(rd == 0 && pa == exp_pa(mkva(1, 2, 12'hFFC)), "R2 other offset", pa, exp_pa(mkva(1, 2, 12'hFFC)));
    endtask

    task automatic t_pagefault();
        access(mkva(5, 0, 0), 0, 0, pa, pf, prf, dty, rd, cy);
        chk(pf && rd == 1, "R5 level1 absent", 32'(rd), 1);
        access(mkva(5, 0, 0), 0, 0, pa, pf, prf, dty, rd, cy);
        chk(pf && rd == 1, "R5 no install l1", 32'(rd), 1);
        access(mkva(0, 15, 0), 0, 0, pa, pf, prf, dty, rd, cy);
        chk(pf && !prf && rd == 2, "R5 level2 absent", 32'(rd), 2);
        access(mkva(0, 15, 0), 0, 0, pa, pf, prf, dty, rd, cy);
        chk(pf && rd == 2, "R5 no install l2", 32'(rd), 2);
    endtask

    task automatic t_protect();
        access(mkva(1, 6, 0), 0, 1, pa, pf, prf, dty, rd, cy);
        chk(prf === 1'b1, "R6 user on kernel page", 32'(prf), 1);
        access(mkva(1, 6, 0), 0, 0, pa, pf, prf, dty, rd, cy);
        chk(prf === 1'b0, "R6 kernel ignores user bit", 32'(prf), 0);
        access(mkva(1, 1, 0), 1, 1, pa, pf, prf, dty, rd, cy);
        chk(prf === 1'b1, "R6 write to readonly", 32'(prf), 1);
        access(mkva(1, 1, 0), 0, 1, pa, pf, prf, dty, rd, cy);
        chk(prf === 1'b0, "R6 user read ok", 32'(prf), 0);
        access(mkva(1, 14, 0), 0, 0, pa, pf, prf, dty, rd, cy);
        chk(prf === 1'b1, "R6 read of unreadable", 32'(prf), 1);
        access(mkva(1, 14, 0), 1, 0, pa, pf, prf, dty, rd, cy);
        chk(prf === 1'b0, "R6 write of writable", 32'(prf), 0);
    endtask

    task automatic t_dirty();
        do_flush();
        access(mkva(2, 4, 0), 0, 1, pa, pf, prf, dty, rd, cy);
        chk(dty === 1'b0, "R7 fresh clean", 32'(dty), 0);
        access(mkva(2, 4, 0), 1, 1, pa, pf, prf, dty, rd, cy);
        chk(dty === 1'b0 && !prf, "R7 first write sees clean", 32'(dty), 0);
        access(mkva(2, 4, 0), 0, 1, pa, pf, prf, dty, rd, cy);
        chk(dty === 1'b1, "R7 dirty after write", 32'(dty), 1);
        access(mkva(2, 1, 0), 1, 0, pa, pf, prf, dty, rd, cy);
        access(mkva(2, 1, 0), 0, 0, pa, pf, prf, dty, rd, cy);
        chk(dty === 1'b0, "R7 denied write stays clean", 32'(dty), 0);
    endtask

    task automatic t_fifo();
        do_flush();
        for (int i = 0; i < 9; i++) access(mkva(3, i, 0), 0, 0, pa, pf, prf, dty, rd, cy);
        access(mkva(3, 1, 0), 0, 0, pa, pf, prf, dty, rd, cy);
        chk(rd == 0, "R8 second-oldest kept", rd, 0);
        access(mkva(3, 0, 0), 0, 0, pa, pf, prf, dty, rd, cy);
        chk(rd == 2, "R8 oldest evicted", rd, 2);
    endtask

    task automatic t_flush();
        int r0;
        access(mkva(0, 7, 0), 0, 0, pa, pf, prf, dty, rd, cy);
        do_flush();
        access(mkva(0, 7, 0), 0, 0, pa, pf, prf, dty, rd, cy);
        chk(rd == 2, "R9 flush empties", rd, 2);
        // flush together with a hit
        @(negedge clk);
        req_valid = 1; req_vaddr = mkva(0, 7, 8); req_write = 0; req_user = 0; flush = 1;
        #1;
        chk(resp_valid === 1'b1 && resp_paddr == exp_pa(mkva(0, 7, 8)), "R9 hit in flush cycle", resp_paddr, exp_pa(mkva(0, 7, 8)));
        @(negedge clk); flush = 0; req_valid = 0;
        access(mkva(0, 7, 0), 0, 0, pa, pf, prf, dty, rd, cy);
        chk(rd == 2, "R9 flush after hit", rd, 2);
        // flush together with refill
        @(negedge clk);
        req_valid = 1; req_vaddr = mkva(0, 9, 0);
        r0 = rd_count;
        while (!(mem_rsp_valid && rd_count - r0 == 2)) @(negedge clk);
        @(negedge clk); flush = 1;
        #1;
        chk(resp_valid === 1'b0, "R9 no resp in refill", 32'(resp_valid), 0);
        @(negedge clk); flush = 0;
        wait_resp(cy);
        chk(resp_paddr == exp_pa(mkva(0, 9, 0)), "R9 paddr after rewalk", resp_paddr, exp_pa(mkva(0, 9, 0)));
        @(negedge clk); req_valid = 0;
        chk(rd_count - r0 == 4, "R9 flush wins over refill", rd_count - r0, 4);
    endtask

    task automatic t_latency();
        lat = 3; rdy_delay = 2; wait_cnt = 2;
        access(mkva(2, 10, 12'h10), 0, 0, pa, pf, prf, dty, rd, cy);
        chk(rd == 2 && pa == exp_pa(mkva(2, 10, 12'h10)), "R10 slow memory", pa, exp_pa(mkva(2, 10, 12'h10)));
        chk(rd_log[(rd_count - 1) % 4] == 32'h00102028, "R10 address held", rd_log[(rd_count - 1) % 4], 32'h00102028);
        lat = 0; rdy_delay = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_miss_hit();
        t_pagefault();
        t_protect();
        t_dirty();
        t_fifo();
        t_flush();
        t_latency();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule